// File: doc/BRIEF.md
# Debug-State Asynchronous Abort Controller

This block decides the fate of an asynchronous (imprecise) data abort, both while the core is halted for debug and while it runs normally. It watches an abort strobe and its external/internal qualifier, the halted flag, a strobe that marks leaving the halted state, a discard control, the abort mask and a selector for the debug-architecture version. From these it drives three signals. `sticky_abort` is a sticky status bit. `abort_pending` is the pending-abort flag reported to the interrupt status register. `abort_take` is a one-cycle request that tells the core to take the abort. `sticky_clr` clears the sticky bit. The block produces control and status signals only. Register updates, vectoring and fault recording belong to other blocks.

With the two newer versions, an abort that arrives while halted never raises an exception, and the mask bit has no effect. The discard control then picks one of two outcomes. With discard set, the abort is recorded in the sticky bit and dropped. With discard clear, the abort is held in a one-deep latch and raised when the core leaves the halted state. With the legacy version, nothing is suppressed: an unmasked abort is taken at once, and a masked one waits until the mask drops.

The sequencer has four states. `ST_NORM` holds no abort. `ST_DEFER` holds an abort until debug exit. `ST_LWAIT` holds a legacy masked abort until the mask drops. `ST_FIRE` is the single cycle in which `abort_take` is high.

Its transitions are as follows:
- `ST_NORM` and `ST_FIRE` both go to `ST_FIRE` on a take route, to `ST_DEFER` on a defer route, to `ST_LWAIT` on a legacy-wait route, and to `ST_NORM` otherwise.
- `ST_DEFER` goes to `ST_FIRE` on `debug_exit`.
- `ST_LWAIT` goes to `ST_FIRE` when `abort_mask` is low.

Top module: `dbg_async_abort_ctrl`

## Requirements
- R1: After reset, `sticky_abort`, `abort_pending` and `abort_take` are all 0.
- R2: With `in_debug` low, an abort with `abort_mask` 0 gives `abort_take` high for exactly the next cycle. With `abort_mask` 1, the abort is dropped.
- R3: With `ver_sel` at intermediate (2'b01) or current (2'b10 or 2'b11), an abort while `in_debug` is high never drives `abort_take` while halted, whatever the value of `abort_mask`.
- R4: With a newer version and `discard_en` 1, an abort while halted sets `sticky_abort` on the next cycle. It leaves `abort_pending` unchanged and produces no `abort_take` at debug exit.
- R5: With `discard_en` 0, an abort while halted sets `sticky_abort` under the intermediate version and leaves it unchanged under the current version.
- R6: With a newer version and `discard_en` 0, an abort while halted is held. `abort_take` is then high for exactly the cycle after the `debug_exit` strobe.
- R7: An external abort (`abort_ext` 1) held under R6 sets `abort_pending` on the next cycle. `abort_pending` stays high through the `abort_take` cycle and is 0 in the cycle after it. An internal held abort leaves `abort_pending` at 0.
- R8: Several aborts held during one debug session give a single `abort_take` pulse at exit.
- R9: With the legacy version (`ver_sel` 2'b00), an unmasked abort while halted gives `abort_take` on the next cycle. A masked abort instead gives `abort_take` in the cycle after `abort_mask` is first seen at 0.
- R10: `sticky_abort` keeps its value until a `sticky_clr` pulse or reset. When a set and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| abort_req | input | 1 | Asynchronous abort strobe, one cycle per abort |
| abort_ext | input | 1 | 1 = the abort is external |
| in_debug | input | 1 | Core is halted in debug state |
| debug_exit | input | 1 | One-cycle strobe marking exit from debug state |
| discard_en | input | 1 | 1 = drop aborts that arrive while halted |
| abort_mask | input | 1 | Abort mask bit |
| ver_sel | input | 2 | Debug version: 00 legacy, 01 intermediate, 10/11 current |
| sticky_clr | input | 1 | Clears the sticky abort bit |
| sticky_abort | output | 1 | Sticky abort status |
| abort_pending | output | 1 | External abort pending, for the interrupt status register |
| abort_take | output | 1 | One-cycle request to take the abort |

## Verification
The hardest situations to reach are a new abort arriving in the same cycle as a debug-exit strobe, and a burst of held aborts with mixed external qualifiers that must still collapse into one pulse. The stimulus builds a debug session containing several aborts, some of them external and some internal. It places the last abort in the cycle that carries `debug_exit`. The stimulus also drives a sticky set and a `sticky_clr` in the same cycle, and it lowers the mask on a waiting legacy abort after several cycles of delay.

// File: rtl/dbg_abt_pkg.sv
package dbg_abt_pkg;
    localparam int VER_W = 2;

    typedef enum logic [VER_W-1:0] {
        VER_LEGACY  = 2'b00,
        VER_INTER   = 2'b01,
        VER_CURRENT = 2'b10,
        VER_RSVD    = 2'b11
    } dbg_ver_e;

    typedef enum logic [1:0] {
        ST_NORM,
        ST_DEFER,
        ST_LWAIT,
        ST_FIRE
    } abt_state_e;

    typedef enum logic [1:0] {
        RT_NONE,
        RT_TAKE,
        RT_DEFER,
        RT_LWAIT
    } abt_route_e;
endpackage

// File: rtl/abt_classify.sv
module abt_classify
    import dbg_abt_pkg::*;
(
    input  logic             abort_req,
    input  logic             abort_ext,
    input  logic             in_debug,
    input  logic             discard_en,
    input  logic             abort_mask,
    input  logic [VER_W-1:0] ver_sel,
    output abt_route_e       route,
    output logic             set_sticky,
    output logic             set_pend
);
    logic is_legacy;
    logic is_inter;

    assign is_legacy = (ver_sel == VER_LEGACY);
    assign is_inter  = (ver_sel == VER_INTER);

    always_comb begin
        route      = RT_NONE;
        set_sticky = 1'b0;
        set_pend   = 1'b0;
        if (abort_req) begin
            if (!in_debug) begin
                route = abort_mask ? RT_NONE : RT_TAKE;
            end else if (is_legacy) begin
                route = abort_mask ? RT_LWAIT : RT_TAKE;
            end else if (discard_en) begin
                set_sticky = 1'b1;
            end else begin
                route      = RT_DEFER;
                set_sticky = is_inter;
                set_pend   = abort_ext;
            end
        end
    end
endmodule

// File: rtl/abt_seq_fsm.sv
module abt_seq_fsm
    import dbg_abt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  abt_route_e route,
    input  logic       debug_exit,
    input  logic       abort_mask,
    output abt_state_e state_o,
    output logic       fire_o
);
    abt_state_e state_q;
    abt_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NORM;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORM, ST_FIRE: begin
                unique case (route)
                    RT_TAKE:  state_d = ST_FIRE;
                    RT_DEFER: state_d = ST_DEFER;
                    RT_LWAIT: state_d = ST_LWAIT;
                    default:  state_d = ST_NORM;
                endcase
            end
            ST_DEFER: state_d = debug_exit ? ST_FIRE : ST_DEFER;
            ST_LWAIT: state_d = abort_mask ? ST_LWAIT : ST_FIRE;
            default:  state_d = ST_NORM;
        endcase
    end

    always_comb begin
        fire_o  = (state_q == ST_FIRE);
        state_o = state_q;
    end
endmodule

// File: rtl/abt_status.sv
module abt_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_sticky,
    input  logic sticky_clr,
    input  logic set_pend,
    input  logic fire,
    output logic sticky_q,
    output logic pend_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky_q <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            if (set_sticky)      sticky_q <= 1'b1;
            else if (sticky_clr) sticky_q <= 1'b0;
            if (set_pend)        pend_q   <= 1'b1;
            else if (fire)       pend_q   <= 1'b0;
        end
    end
endmodule

// File: rtl/dbg_async_abort_ctrl.sv
module dbg_async_abort_ctrl
    import dbg_abt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort_req,
    input  logic             abort_ext,
    input  logic             in_debug,
    input  logic             debug_exit,
    input  logic             discard_en,
    input  logic             abort_mask,
    input  logic [VER_W-1:0] ver_sel,
    input  logic             sticky_clr,
    output logic             sticky_abort,
    output logic             abort_pending,
    output logic             abort_take
);
    abt_route_e route;
    abt_state_e fsm_state;
    logic       set_sticky;
    logic       set_pend;
    logic       fire;

    abt_classify u_cls (
        .abort_req  (abort_req),
        .abort_ext  (abort_ext),
        .in_debug   (in_debug),
        .discard_en (discard_en),
        .abort_mask (abort_mask),
        .ver_sel    (ver_sel),
        .route      (route),
        .set_sticky (set_sticky),
        .set_pend   (set_pend)
    );

    abt_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .route      (route),
        .debug_exit (debug_exit),
        .abort_mask (abort_mask),
        .state_o    (fsm_state),
        .fire_o     (fire)
    );

    abt_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_sticky (set_sticky),
        .sticky_clr (sticky_clr),
        .set_pend   (set_pend),
        .fire       (fire),
        .sticky_q   (sticky_abort),
        .pend_q     (abort_pending)
    );

    assign abort_take = fire;
endmodule

// File: rtl/dbg_abort_chk.sv
module dbg_abort_chk
    import dbg_abt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             abort_req,
    input logic             abort_ext,
    input logic             in_debug,
    input logic             debug_exit,
    input logic             discard_en,
    input logic             abort_mask,
    input logic [VER_W-1:0] ver_sel,
    input logic             sticky_clr,
    input logic             sticky_abort,
    input logic             abort_pending,
    input logic             abort_take,
    input abt_state_e       state
);
    // R2
    take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_take && !abort_req |=> !abort_take);

    // R3
    no_take_in_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORM || state == ST_FIRE) && in_debug && abort_req && ver_sel != 2'b00
        |=> !abort_take);

    // R4
    sticky_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_debug && abort_req && ver_sel != 2'b00 && discard_en |=> sticky_abort);

    // R5
    sticky_kept_current_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_debug && abort_req && ver_sel == 2'b10 && !discard_en && !sticky_clr
        |=> $stable(sticky_abort));

    // R6
    exit_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DEFER && debug_exit |=> abort_take);

    // R7
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_debug && abort_req && abort_ext && !discard_en && ver_sel != 2'b00
        |=> abort_pending);

    // R7
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_take && !(abort_req && in_debug) |=> !abort_pending);

    // R9
    legacy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_LWAIT && !abort_mask |=> abort_take);

    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_abort && !sticky_clr |=> sticky_abort);
endmodule

bind dbg_async_abort_ctrl dbg_abort_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .abort_req     (abort_req),
    .abort_ext     (abort_ext),
    .in_debug      (in_debug),
    .debug_exit    (debug_exit),
    .discard_en    (discard_en),
    .abort_mask    (abort_mask),
    .ver_sel       (ver_sel),
    .sticky_clr    (sticky_clr),
    .sticky_abort  (sticky_abort),
    .abort_pending (abort_pending),
    .abort_take    (abort_take),
    .state         (fsm_state)
);

// File: tb/dbg_async_abort_ctrl_tb.sv
module dbg_async_abort_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       abort_req = 1'b0, abort_ext = 1'b0, in_debug = 1'b0, debug_exit = 1'b0;
    logic       discard_en = 1'b0, abort_mask = 1'b0, sticky_clr = 1'b0;
    logic [1:0] ver_sel = 2'b10;
    logic       sticky_abort, abort_pending, abort_take;

    int    n_chk = 0;
    int    n_fail = 0;
    int    n_cyc = 0;
    int    n_take = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // behavioural reference state
    bit m_held, m_lwait, m_take, m_sticky, m_pend;

    always #10 clk = ~clk;

    dbg_async_abort_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .abort_req(abort_req), .abort_ext(abort_ext),
        .in_debug(in_debug), .debug_exit(debug_exit), .discard_en(discard_en),
        .abort_mask(abort_mask), .ver_sel(ver_sel), .sticky_clr(sticky_clr),
        .sticky_abort(sticky_abort), .abort_pending(abort_pending), .abort_take(abort_take)
    );

    task automatic chk(string tag, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        bit nxt;
        bit leg;
        bit inter;
        if (!rst_n) begin
            m_held = 0; m_lwait = 0; m_take = 0; m_sticky = 0; m_pend = 0;
        end else begin
            nxt   = 0;
            leg   = (ver_sel == 2'b00);
            inter = (ver_sel == 2'b01);
            if (m_held) begin
                if (debug_exit) begin nxt = 1; m_held = 0; end
            end else if (m_lwait) begin
                if (!abort_mask) begin nxt = 1; m_lwait = 0; end
            end else if (abort_req) begin
                if (!in_debug)         nxt = !abort_mask;
                else if (leg) begin
                    if (abort_mask) m_lwait = 1;
                    else            nxt = 1;
                end else if (!discard_en) m_held = 1;
            end
            if (abort_req && in_debug && !leg && !discard_en && abort_ext) m_pend = 1;
            else if (m_take) m_pend = 0;
            if (abort_req && in_debug && !leg && (discard_en || inter)) m_sticky = 1;
            else if (sticky_clr) m_sticky = 0;
            m_take = nxt;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            chk(cur_req, "abort_take",    abort_take,    m_take);
            chk(cur_req, "sticky_abort",  sticky_abort,  m_sticky);
            chk(cur_req, "abort_pending", abort_pending, m_pend);
            if (abort_take === 1'b1) n_take++;
        end
    end

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 20000 && !done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", n_cyc);
            finish_run();
        end
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_abort(logic ext);
        abort_req = 1'b1; abort_ext = ext;
        tick(1);
        abort_req = 1'b0; abort_ext = 1'b0;
    endtask

    task automatic leave_debug();
        debug_exit = 1'b1;
        tick(1);
        debug_exit = 1'b0; in_debug = 1'b0;
    endtask

    initial begin
        int t0;
        tick(2);
        cur_req = "R1";
        chk("R1", "take in reset", abort_take, 1'b0);
        chk("R1", "sticky in reset", sticky_abort, 1'b0);
        rst_n = 1'b1;
        tick(1);
        chk("R1", "pending after reset", abort_pending, 1'b0);

        // R2 outside debug
        cur_req = "R2";
        pulse_abort(1'b1);
        chk("R2", "take next cycle", abort_take, 1'b1);
        tick(1);
        chk("R2", "take one cycle", abort_take, 1'b0);
        abort_mask = 1'b1;
        pulse_abort(1'b0);
        chk("R2", "masked dropped", abort_take, 1'b0);
        abort_mask = 1'b0;
        tick(2);

        // R3 R4 current, discard
        cur_req = "R4";
        ver_sel = 2'b10; in_debug = 1'b1; discard_en = 1'b1;
        tick(1);
        pulse_abort(1'b1);
        chk("R3", "no take while halted", abort_take, 1'b0);
        chk("R4", "sticky set on discard", sticky_abort, 1'b1);
        chk("R4", "pending untouched", abort_pending, 1'b0);
        leave_debug();
        chk("R4", "no take after exit", abort_take, 1'b0);
        tick(2);
        cur_req = "R10";
        chk("R10", "sticky holds", sticky_abort, 1'b1);
        sticky_clr = 1'b1; tick(1); sticky_clr = 1'b0;
        chk("R10", "sticky cleared", sticky_abort, 1'b0);

        // R5 R6 R7 current, hold external
        cur_req = "R6";
        discard_en = 1'b0; in_debug = 1'b1; abort_mask = 1'b1;
        tick(1);
        pulse_abort(1'b1);
        chk("R5", "current keeps sticky", sticky_abort, 1'b0);
        chk("R7", "pending set", abort_pending, 1'b1);
        chk("R3", "mask ignored, no take", abort_take, 1'b0);
        tick(3);
        leave_debug();
        chk("R6", "take after exit", abort_take, 1'b1);
        chk("R7", "pending during take", abort_pending, 1'b1);
        tick(1);
        chk("R7", "pending cleared", abort_pending, 1'b0);
        abort_mask = 1'b0;
        tick(1);

        // R5 intermediate, internal
        cur_req = "R5";
        ver_sel = 2'b01; in_debug = 1'b1;
        tick(1);
        pulse_abort(1'b0);
        chk("R5", "intermediate sets sticky", sticky_abort, 1'b1);
        chk("R7", "internal leaves pending", abort_pending, 1'b0);
        leave_debug();
        chk("R6", "internal held take", abort_take, 1'b1);
        tick(1);
        sticky_clr = 1'b1; tick(1); sticky_clr = 1'b0;

        // R8 merge with abort on exit cycle; R11-style reserved code
        cur_req = "R8";
        ver_sel = 2'b11; in_debug = 1'b1;
        tick(1);
        pulse_abort(1'b0); tick(1);
        pulse_abort(1'b1);
        chk("R3", "reserved code acts as current", sticky_abort, 1'b0);
        t0 = n_take;
        abort_req = 1'b1; debug_exit = 1'b1;
        tick(1);
        abort_req = 1'b0; debug_exit = 1'b0; in_debug = 1'b0;
        tick(4);
        chk("R8", "single merged pulse", (n_take - t0 == 1), 1'b1);

        // R9 legacy
        cur_req = "R9";
        ver_sel = 2'b00; in_debug = 1'b1;
        tick(1);
        pulse_abort(1'b1);
        chk("R9", "legacy unmasked take", abort_take, 1'b1);
        chk("R9", "legacy no sticky", sticky_abort, 1'b0);
        abort_mask = 1'b1;
        pulse_abort(1'b0);
        tick(3);
        chk("R9", "legacy masked waits", abort_take, 1'b0);
        abort_mask = 1'b0;
        tick(1);
        chk("R9", "legacy take after unmask", abort_take, 1'b1);
        tick(1);
        in_debug = 1'b0;

        // R10 set and clear together
        cur_req = "R10";
        ver_sel = 2'b10; in_debug = 1'b1; discard_en = 1'b1;
        tick(1);
        abort_req = 1'b1; sticky_clr = 1'b1;
        tick(1);
        abort_req = 1'b0; sticky_clr = 1'b0;
        chk("R10", "set wins over clear", sticky_abort, 1'b1);
        tick(2);

        done = 1'b1;
        finish_run();
    end
endmodule